// File: doc/BRIEF.md
# Smooth Gain Ramp Controller

This block computes the gain for the left and right channels of a stereo digital microphone path. Each channel has a 4-bit coarse gain code that selects a level from -12 dB to +10.5 dB in 1.5 dB increments. When a code changes, the channel's gain does not jump to the new level. It moves toward the new level in small fine increments.

A shared interval timer counts output-rate sample pulses. Each time a programmed number of pulses has passed, the timer allows one fine increment on both channels. Soft mute uses the same mechanism: while mute is on, each channel ramps down to a deep attenuation floor. When mute is released, each channel ramps back up to its coded level.

Gain is reported as a signed value in hundredths of a dB. A per-channel busy flag shows that the channel is still ramping. Downstream logic converts the gain to linear scale and applies it to the samples.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both gains read -1200 and the interval count is zero.
- R2: The effective target of a channel is -1200 + 150 × code when it is not muted. Once settled, each channel holds exactly the target of its own code, independent of the other channel.
- R3: Each fine increment moves the gain by at most 13 when `fine_step_sel` is 0, and by at most 26 when it is 1. The gain moves toward the effective target.
- R4: Interval code 0..7 selects 2, 3, 4, 5, 6, 8, 12 or 16 units of `INTERVAL_UNIT` sample pulses between increments. The default unit of 32 gives 64, 96, 128, 160, 192, 256, 384 or 512 pulses. An increment takes effect on the clock edge that samples the pulse completing the interval, and the count then restarts from zero. If the code is reduced to a limit at or below the current count, the next pulse completes the interval.
- R5: When the remaining distance is no larger than one fine increment, the increment sets the gain exactly to the target and never passes it.
- R6: With `soft_mute` high, the effective target of both channels is -12000. With it low, the gains ramp back to their coded targets.
- R7: If a target changes during a ramp, the ramp continues from the current gain toward the new target, and the interval count is not restarted.
- R8: Each busy flag is high exactly when that channel's gain differs from its effective target.
- R9: In a cycle where `sample_pulse` is low, neither the gains nor the interval count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_pulse | input | 1 | One-cycle pulse at the output sample rate |
| left_code | input | 4 | Coarse gain code, left channel |
| right_code | input | 4 | Coarse gain code, right channel |
| soft_mute | input | 1 | Ramp both channels to the attenuation floor |
| fine_step_sel | input | 1 | 0: 13 centi-dB increments, 1: 26 centi-dB increments |
| interval_code | input | 3 | Number of sample pulses between increments |
| left_gain | output | 16 | Current left gain, signed centi-dB |
| right_gain | output | 16 | Current right gain, signed centi-dB |
| left_busy | output | 1 | Left channel is ramping |
| right_busy | output | 1 | Right channel is ramping |

## Verification
The bench builds the block with `INTERVAL_UNIT` = 1, which shortens the intervals to 2 to 16 pulses. At that length every interval code and both step sizes can be swept, and every code from 0 to 15 can be ramped to completion. A full mute-and-release ramp from the highest level down to -12000 and back also fits in the run.

The bench holds `sample_pulse` high on every cycle in some phases and pulses it sparsely in others. It changes targets and interval codes during ramps, so the carried-over count and the clamped final increment are both compared cycle by cycle against an arithmetic model.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;

    localparam int GAIN_W = 16;

    typedef logic signed [GAIN_W-1:0] cdb_t;

    typedef struct packed {
        cdb_t gain;
    } ch_state_t;

    // Interval multiplier for each 3-bit interval code
    function automatic int interval_mult(input logic [2:0] code);
        case (code)
            3'd0:    return 2;
            3'd1:    return 3;
            3'd2:    return 4;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 8;
            3'd6:    return 12;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/gr_interval_timer.sv
module gr_interval_timer
    import gain_ramp_pkg::*;
#(
    parameter int INTERVAL_UNIT = 32,
    parameter int CNT_W         = $clog2(16 * INTERVAL_UNIT + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_pulse,
    input  logic [2:0] interval_code,
    output logic       step_tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    logic [CNT_W-1:0] limit_m1;

    always_comb begin
        limit_m1  = CNT_W'(interval_mult(interval_code) * INTERVAL_UNIT - 1);
        step_tick = sample_pulse && (st_q.cnt >= limit_m1);
        st_d      = st_q;
        if (sample_pulse) begin
            st_d.cnt = step_tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R4
    tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
        step_tick |=> (st_q.cnt == '0));

    // R9
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_pulse |=> $stable(st_q.cnt));

endmodule

// File: rtl/gr_channel_ramp.sv
module gr_channel_ramp
    import gain_ramp_pkg::*;
#(
    parameter int CODE_W    = 4,
    parameter int BASE_CDB  = -1200,
    parameter int CODE_CDB  = 150,
    parameter int FLOOR_CDB = -12000,
    parameter int FINE_LO   = 13,
    parameter int FINE_HI   = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] target_code,
    input  logic              mute,
    input  logic              fine_sel,
    input  logic              step_tick,
    output cdb_t              gain,
    output logic              busy
);

    localparam int TOP_CDB = BASE_CDB + CODE_CDB * ((1 << CODE_W) - 1);

    ch_state_t st_d, st_q;
    int        tgt_i;
    int        step_i;
    int        dist_i;

    always_comb begin
        tgt_i  = mute ? FLOOR_CDB : BASE_CDB + CODE_CDB * int'(target_code);
        step_i = fine_sel ? FINE_HI : FINE_LO;
        dist_i = tgt_i - int'(st_q.gain);
        st_d   = st_q;
        if (step_tick) begin
            if (dist_i > step_i)
                st_d.gain = cdb_t'(int'(st_q.gain) + step_i);
            else if (dist_i < -step_i)
                st_d.gain = cdb_t'(int'(st_q.gain) - step_i);
            else
                st_d.gain = cdb_t'(tgt_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.gain <= cdb_t'(BASE_CDB);
        else     st_q      <= st_d;
    end

    assign gain = st_q.gain;
    assign busy = (int'(st_q.gain) != tgt_i);

    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        ((int'(gain) - int'($past(gain))) <= $past(step_i)) &&
        ((int'($past(gain)) - int'(gain)) <= $past(step_i)));

    // R5
    no_overshoot_up_chk: assert property (@(posedge clk) disable iff (rst)
        (int'($past(gain)) <= $past(tgt_i)) |-> (int'(gain) <= $past(tgt_i)));

    // R5
    no_overshoot_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (int'($past(gain)) >= $past(tgt_i)) |-> (int'(gain) >= $past(tgt_i)));

    // R6
    gain_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(gain) >= FLOOR_CDB) && (int'(gain) <= TOP_CDB));

    // R9
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !step_tick |=> $stable(gain));

endmodule

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
    import gain_ramp_pkg::*;
#(
    parameter int INTERVAL_UNIT = 32,
    parameter int CODE_W        = 4,
    parameter int BASE_CDB      = -1200,
    parameter int CODE_CDB      = 150,
    parameter int FLOOR_CDB     = -12000,
    parameter int FINE_LO       = 13,
    parameter int FINE_HI       = 26
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_pulse,
    input  logic [CODE_W-1:0]        left_code,
    input  logic [CODE_W-1:0]        right_code,
    input  logic                     soft_mute,
    input  logic                     fine_step_sel,
    input  logic [2:0]               interval_code,
    output logic signed [GAIN_W-1:0] left_gain,
    output logic signed [GAIN_W-1:0] right_gain,
    output logic                     left_busy,
    output logic                     right_busy
);

    localparam int NCH = 2;

    logic              step_tick;
    logic [CODE_W-1:0] code_a [NCH];
    cdb_t              gain_a [NCH];
    logic              busy_a [NCH];

    assign code_a[0] = left_code;
    assign code_a[1] = right_code;

    gr_interval_timer #(
        .INTERVAL_UNIT (INTERVAL_UNIT)
    ) u_timer (
        .clk           (clk),
        .rst           (rst),
        .sample_pulse  (sample_pulse),
        .interval_code (interval_code),
        .step_tick     (step_tick)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        gr_channel_ramp #(
            .CODE_W    (CODE_W),
            .BASE_CDB  (BASE_CDB),
            .CODE_CDB  (CODE_CDB),
            .FLOOR_CDB (FLOOR_CDB),
            .FINE_LO   (FINE_LO),
            .FINE_HI   (FINE_HI)
        ) u_ramp (
            .clk         (clk),
            .rst         (rst),
            .target_code (code_a[ch]),
            .mute        (soft_mute),
            .fine_sel    (fine_step_sel),
            .step_tick   (step_tick),
            .gain        (gain_a[ch]),
            .busy        (busy_a[ch])
        );
    end

    assign left_gain  = gain_a[0];
    assign right_gain = gain_a[1];
    assign left_busy  = busy_a[0];
    assign right_busy = busy_a[1];

    // R2
    settled_left_chk: assert property (@(posedge clk) disable iff (rst)
        (!left_busy && !soft_mute) |-> (int'(left_gain) == BASE_CDB + CODE_CDB * int'(left_code)));

    // R6
    muted_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_mute && !right_busy) |-> (int'(right_gain) == FLOOR_CDB));

endmodule

// File: tb/gain_ramp_ctrl_test.sv
module gain_ramp_ctrl_test;

    localparam int UNIT = 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_pulse = 1'b0;
    logic [3:0]        left_code = '0;
    logic [3:0]        right_code = '0;
    logic              soft_mute = 1'b0;
    logic              fine_step_sel = 1'b0;
    logic [2:0]        interval_code = '0;
    logic signed [15:0] left_gain, right_gain;
    logic              left_busy, right_busy;

    int errors = 0;
    int checks = 0;
    int mcnt   = 0;
    int mg [2] = '{-1200, -1200};

    always #10 clk = ~clk;

    gain_ramp_ctrl #(.INTERVAL_UNIT(UNIT)) uut (
        .clk(clk), .rst(rst), .sample_pulse(sample_pulse),
        .left_code(left_code), .right_code(right_code),
        .soft_mute(soft_mute), .fine_step_sel(fine_step_sel),
        .interval_code(interval_code),
        .left_gain(left_gain), .right_gain(right_gain),
        .left_busy(left_busy), .right_busy(right_busy)
    );

    function automatic int mult_of(input int c);
        case (c)
            0: return 2;  1: return 3;  2: return 4;  3: return 5;
            4: return 6;  5: return 8;  6: return 12; default: return 16;
        endcase
    endfunction

    function automatic int tgt_of(input int code, input bit mute);
        return mute ? -12000 : -1200 + 150 * code;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: model update at the edge, compare at the following falling edge
    task automatic cycle(input bit pulse, input string tag);
        int tg [2];
        sample_pulse = pulse;
        @(posedge clk);
        tg[0] = tgt_of(int'(left_code), soft_mute);
        tg[1] = tgt_of(int'(right_code), soft_mute);
        if (pulse) begin
            bit tick = (mcnt >= mult_of(int'(interval_code)) * UNIT - 1);
            mcnt = tick ? 0 : mcnt + 1;
            if (tick) begin
                for (int c = 0; c < 2; c++) begin
                    int st = fine_step_sel ? 26 : 13;
                    int d  = tg[c] - mg[c];
                    if (d > st)       mg[c] = mg[c] + st;
                    else if (d < -st) mg[c] = mg[c] - st;
                    else              mg[c] = tg[c];
                end
            end
        end
        @(negedge clk);
        sample_pulse = 1'b0;
        chk(tag, int'(left_gain), mg[0]);
        chk(tag, int'(right_gain), mg[1]);
        chk("R8", int'(left_busy), int'(mg[0] != tgt_of(int'(left_code), soft_mute)));
        chk("R8", int'(right_busy), int'(mg[1] != tgt_of(int'(right_code), soft_mute)));
    endtask

    task automatic settle(input int every, input string tag);
        int n = 0;
        while ((mg[0] != tgt_of(int'(left_code), soft_mute) ||
                mg[1] != tgt_of(int'(right_code), soft_mute)) && n < 20000) begin
            cycle((n % every) == 0, tag);
            n++;
        end
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", int'(left_gain), -1200);
        chk("R1", int'(right_gain), -1200);
        chk("R1", int'(left_busy), 0);
        rst = 1'b0;
        cycle(1'b0, "R1");

        // R9: targets move, no pulses, nothing changes
        left_code = 4'd15; right_code = 4'd7;
        for (int i = 0; i < 20; i++) cycle(1'b0, "R9");

        // R4 / R3: every interval code with both step sizes
        for (int ic = 0; ic < 8; ic++) begin
            for (int fs = 0; fs < 2; fs++) begin
                interval_code = 3'(ic);
                fine_step_sel = fs[0];
                left_code  = 4'((ic * 2 + fs * 5) % 16);
                right_code = 4'(15 - (ic * 3 + fs) % 16);
                settle(1, "R4");
            end
        end

        // R2: every code on both channels, independently
        interval_code = 3'd0; fine_step_sel = 1'b1;
        for (int c = 0; c < 16; c++) begin
            left_code = 4'(c); right_code = 4'(15 - c);
            settle(1, "R2");
            chk("R2", int'(left_gain), -1200 + 150 * c);
            chk("R2", int'(right_gain), -1200 + 150 * (15 - c));
        end

        // R5: 150 is not a multiple of 13, final increment clamps
        fine_step_sel = 1'b0;
        left_code = 4'd0; right_code = 4'd0; settle(1, "R5");
        left_code = 4'd1; right_code = 4'd1; settle(1, "R5");
        chk("R5", int'(left_gain), -1050);

        // R6: mute ramp to floor and back
        left_code = 4'd15; right_code = 4'd9; fine_step_sel = 1'b1;
        settle(1, "R6");
        soft_mute = 1'b1; settle(1, "R6");
        chk("R6", int'(left_gain), -12000);
        chk("R6", int'(right_gain), -12000);
        soft_mute = 1'b0; settle(1, "R6");
        chk("R6", int'(left_gain), 1050);

        // R7: targets and interval code changed mid-ramp
        interval_code = 3'd7; left_code = 4'd0; right_code = 4'd15;
        for (int i = 0; i < 37; i++) cycle(1'b1, "R7");
        left_code = 4'd12; right_code = 4'd2; interval_code = 3'd1;
        for (int i = 0; i < 29; i++) cycle(1'b1, "R7");
        interval_code = 3'd2;
        settle(1, "R7");

        // R9: sparse pulses
        interval_code = 3'd3; left_code = 4'd4; right_code = 4'd11;
        settle(3, "R9");
        soft_mute = 1'b1;
        for (int i = 0; i < 200; i++) cycle((i % 7) == 0, "R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule